// File: doc/BRIEF.md
# System Error Signal Aggregator

This block collects the error events of a host bridge and folds them into a single active-low, open-drain system error line. The sources are memory ECC errors (correctable and uncorrectable), target aborts on cycles the bridge itself starts on the primary PCI bus or the AGP port, parity errors seen on either bus, and hits on invalid entries of the graphics aperture translation table. The block also checks the address of every AGP master request. It flags a request that misses the aperture window, and separately flags one that misses the window and also lands in the legacy 0xA0000–0xFFFFF hole or at or above top of memory.

A global enable and per-source enable bits arrive on register ports, together with the aperture base, aperture size and top-of-memory values. Each clock in which at least one enabled source fires produces one clock of low drive on the line, one cycle later. Events in adjacent cycles give adjacent low cycles, and simultaneous events share one low cycle. A sticky status bit per source records what happened. Software clears a status bit by writing 1 to it.

Top module: `sysErrAgg`

## Requirements
- R1: While `globalEn` is 0 the line is never driven low, whatever the sources and enables do.
- R2: The correctable ECC error (source 0, enable bit 0) and the uncorrectable ECC error (source 1, enable bit 1) each drive the line only when their own enable bit is 1.
- R3: While `initDone` is 0, ECC error strobes are ignored: they neither drive the line nor set status bits 0 or 1.
- R4: A target abort on the PCI bus (source 8) or on the AGP port (source 9) drives the line for exactly one clock per cycle of abort, gated only by `globalEn`. There is no per-source enable for these two.
- R5: PCI address parity (source 2, enable 2), PCI data parity (source 3, enable 3) and AGP parity (source 4, enable 4) each drive the line only through their own enable bit.
- R6: An invalid translation-table hit (source 5, enable 5) drives the line only when enable bit 5 is 1.
- R7: A valid AGP request whose address is not in [apBase, apBase+apSize) is an outside-aperture event (source 6, enable 6). The end of the window is computed without wrap, one bit wider than the address.
- R8: An outside-aperture request whose address is in 0xA0000..0xFFFFF inclusive, or is at or above `topOfMem`, is also an illegal-access event (source 7, enable 7).
- R9: If any source with its enable set (enable always set for sources 8 and 9) fires in the cycle sampled at clock edge N and `globalEn` is 1, then `serrN` is 0 after edge N and until edge N+1. Otherwise it is 1 in that interval.
- R10: Status bit i is set at the edge that samples source i firing, regardless of enables (for sources 0 and 1 only while `initDone` is 1). It stays set until a 1 is written to `statusClr[i]`. A set in the same cycle as a clear wins.
- R11: `serrOe` is 1 exactly in the cycles in which `serrN` is 0. Otherwise the line is released.
- R12: A synchronous reset (`rst`=1 at an edge) clears all status bits and releases the line, regardless of the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| globalEn | input | 1 | Global system-error enable |
| srcEnable | input | 8 | Per-source enables for sources 0..7 |
| initDone | input | 1 | Initialization complete; ECC errors are ignored while 0 |
| eccSingle | input | 1 | Correctable ECC error strobe |
| eccMulti | input | 1 | Uncorrectable ECC error strobe |
| pciAddrPar | input | 1 | PCI address-phase parity error strobe |
| pciDataPar | input | 1 | PCI data-phase parity error strobe |
| agpPar | input | 1 | AGP parity error strobe |
| gartInvalid | input | 1 | Invalid translation-table entry hit strobe |
| pciTgtAbort | input | 1 | Target abort on a bridge-started PCI cycle |
| agpTgtAbort | input | 1 | Target abort on a bridge-started AGP cycle |
| agpReqValid | input | 1 | AGP master request address is valid this cycle |
| agpReqAddr | input | 32 | AGP master request address |
| apBase | input | 32 | Aperture window base address |
| apSize | input | 32 | Aperture window size in bytes |
| topOfMem | input | 32 | Top of main memory; addresses at or above it are illegal |
| statusClr | input | 10 | Write-1-to-clear strobes for the status bits |
| status | output | 10 | Sticky status, bit i for source i |
| serrN | output | 1 | System error line value, active low |
| serrOe | output | 1 | Output enable for the open-drain line |

## Verification
The assertions check on every cycle that a cleared global enable keeps the line released. They also check that a target abort under global enable is followed by a driven cycle, that ECC status cannot appear before initialization completes, that status bits hold until cleared and always catch a logged event, and that reset releases the line and clears status. The address decode boundaries (the aperture edges, the two ends of the legacy hole, top of memory and a window that ends at the top of the address space) can only be shown by the bench's directed scenarios. The same holds for the pulse train for adjacent and simultaneous events and for the race between a clear and a set in one cycle. The bench checks all of these against a model computed from the requirements.

// File: rtl/sysErrPkg.sv
package sysErrPkg;
  // Source numbering: gatable sources first, target aborts last
  localparam int NSRC      = 10;
  localparam int NGATE     = 8;
  localparam int SRC_ECC_SB = 0;
  localparam int SRC_ECC_MB = 1;
  localparam int SRC_PCI_AP = 2;
  localparam int SRC_PCI_DP = 3;
  localparam int SRC_AGP_P  = 4;
  localparam int SRC_GART   = 5;
  localparam int SRC_AGP_OUT = 6;
  localparam int SRC_AGP_ILL = 7;
  localparam int SRC_PCI_TA = 8;
  localparam int SRC_AGP_TA = 9;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NSRC-1:0] setMask;  // sources to log this cycle
    logic            fire;     // drive the line next cycle
  } errStrobe_t;
endpackage

// File: rtl/sysErrCtrl.sv
module sysErrCtrl
  import sysErrPkg::*;
(
  input  logic             globalEn,
  input  logic [NGATE-1:0] srcEnable,
  input  logic             initDone,
  input  logic             eccSingle,
  input  logic             eccMulti,
  input  logic             pciAddrPar,
  input  logic             pciDataPar,
  input  logic             agpPar,
  input  logic             gartInvalid,
  input  logic             pciTgtAbort,
  input  logic             agpTgtAbort,
  input  logic             agpOutside,
  input  logic             agpIllegal,
  output errStrobe_t       strobe
);
  localparam int NFIXED = NSRC - NGATE;

  logic [NSRC-1:0] rawEv;
  logic [NSRC-1:0] validEv;
  logic [NSRC-1:0] enMask;

  always_comb begin
    rawEv = '0;
    rawEv[SRC_ECC_SB]  = eccSingle;
    rawEv[SRC_ECC_MB]  = eccMulti;
    rawEv[SRC_PCI_AP]  = pciAddrPar;
    rawEv[SRC_PCI_DP]  = pciDataPar;
    rawEv[SRC_AGP_P]   = agpPar;
    rawEv[SRC_GART]    = gartInvalid;
    rawEv[SRC_AGP_OUT] = agpOutside;
    rawEv[SRC_AGP_ILL] = agpIllegal;
    rawEv[SRC_PCI_TA]  = pciTgtAbort;
    rawEv[SRC_AGP_TA]  = agpTgtAbort;
  end

  // ECC sources are masked until initialization is complete
  for (genvar i = 0; i < NSRC; i++) begin : g_valid
    if (i == SRC_ECC_SB || i == SRC_ECC_MB) begin : g_ecc
      assign validEv[i] = rawEv[i] & initDone;
    end else begin : g_plain
      assign validEv[i] = rawEv[i];
    end
  end

  // Target aborts carry no individual enable
  assign enMask = {{NFIXED{1'b1}}, srcEnable};

  always_comb begin
    strobe.setMask = validEv;
    strobe.fire    = globalEn & (|(validEv & enMask));
  end
endmodule

// File: rtl/sysErrDatapath.sv
module sysErrDatapath
  import sysErrPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] HOLE_LO = 'h000A_0000,
  parameter logic [ADDR_W-1:0] HOLE_HI = 'h000F_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              agpReqValid,
  input  logic [ADDR_W-1:0] agpReqAddr,
  input  logic [ADDR_W-1:0] apBase,
  input  logic [ADDR_W-1:0] apSize,
  input  logic [ADDR_W-1:0] topOfMem,
  input  logic [NSRC-1:0]   statusClr,
  input  errStrobe_t        strobe,
  output logic              agpOutside,
  output logic              agpIllegal,
  output logic [NSRC-1:0]   statusQ,
  output logic              pulseQ
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] apEnd;
  logic             inAperture;
  logic             inHole;
  logic             aboveTom;

  // Address decode for AGP master requests
  always_comb begin
    apEnd      = {1'b0, apBase} + {1'b0, apSize};
    inAperture = (agpReqAddr >= apBase) && ({1'b0, agpReqAddr} < apEnd);
    inHole     = (agpReqAddr >= HOLE_LO) && (agpReqAddr <= HOLE_HI);
    aboveTom   = (agpReqAddr >= topOfMem);
    agpOutside = agpReqValid && !inAperture;
    agpIllegal = agpOutside && (inHole || aboveTom);
  end

  // Sticky status, set has priority over write-1-to-clear
  for (genvar i = 0; i < NSRC; i++) begin : g_stat
    always_ff @(posedge clk) begin
      if (rst)                    statusQ[i] <= 1'b0;
      else if (strobe.setMask[i]) statusQ[i] <= 1'b1;
      else if (statusClr[i])      statusQ[i] <= 1'b0;
    end

    // R10: a set bit survives unless cleared
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      (statusQ[i] && !statusClr[i]) |=> statusQ[i]);
    // R10: a logged event always shows next cycle
    a_r10_set: assert property (@(posedge clk) disable iff (rst)
      strobe.setMask[i] |=> statusQ[i]);
  end

  // One-clock drive per qualifying cycle
  always_ff @(posedge clk) begin
    if (rst) pulseQ <= 1'b0;
    else     pulseQ <= strobe.fire;
  end
endmodule

// File: rtl/sysErrAgg.sv
module sysErrAgg
  import sysErrPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        globalEn,
  input  logic [7:0]  srcEnable,
  input  logic        initDone,
  input  logic        eccSingle,
  input  logic        eccMulti,
  input  logic        pciAddrPar,
  input  logic        pciDataPar,
  input  logic        agpPar,
  input  logic        gartInvalid,
  input  logic        pciTgtAbort,
  input  logic        agpTgtAbort,
  input  logic        agpReqValid,
  input  logic [31:0] agpReqAddr,
  input  logic [31:0] apBase,
  input  logic [31:0] apSize,
  input  logic [31:0] topOfMem,
  input  logic [9:0]  statusClr,
  output logic [9:0]  status,
  output logic        serrN,
  output logic        serrOe
);
  errStrobe_t strobe;
  logic       agpOutside;
  logic       agpIllegal;
  logic       pulseQ;

  sysErrCtrl i_ctrl (
    .globalEn   (globalEn),
    .srcEnable  (srcEnable),
    .initDone   (initDone),
    .eccSingle  (eccSingle),
    .eccMulti   (eccMulti),
    .pciAddrPar (pciAddrPar),
    .pciDataPar (pciDataPar),
    .agpPar     (agpPar),
    .gartInvalid(gartInvalid),
    .pciTgtAbort(pciTgtAbort),
    .agpTgtAbort(agpTgtAbort),
    .agpOutside (agpOutside),
    .agpIllegal (agpIllegal),
    .strobe     (strobe)
  );

  sysErrDatapath #(.ADDR_W(32)) i_dp (
    .clk        (clk),
    .rst        (rst),
    .agpReqValid(agpReqValid),
    .agpReqAddr (agpReqAddr),
    .apBase     (apBase),
    .apSize     (apSize),
    .topOfMem   (topOfMem),
    .statusClr  (statusClr),
    .strobe     (strobe),
    .agpOutside (agpOutside),
    .agpIllegal (agpIllegal),
    .statusQ    (status),
    .pulseQ     (pulseQ)
  );

  // Open-drain: drive low only while pulsing
  assign serrN  = ~pulseQ;
  assign serrOe = pulseQ;

  // R1: no drive without the global enable
  a_r1_global_gate: assert property (@(posedge clk) disable iff (rst)
    !globalEn |=> !serrOe);

  // R4: an enabled target abort always gives a driven cycle
  a_r4_abort_pulse: assert property (@(posedge clk) disable iff (rst)
    (globalEn && (pciTgtAbort || agpTgtAbort)) |=> (serrOe && !serrN));

  // R3: ECC status cannot appear before initialization completes
  a_r3_ecc_blocked: assert property (@(posedge clk) disable iff (rst)
    (!initDone && !status[0] && !status[1]) |=> (!status[0] && !status[1]));

  // R12: reset releases the line and clears status
  a_r12_reset: assert property (@(posedge clk)
    rst |=> (!serrOe && serrN && status == 10'd0));
endmodule

// File: tb/test_sysErrAgg.sv
`timescale 1ns/1ps
module test_sysErrAgg;
  logic        clk = 1'b0;
  logic        rst;
  logic        globalEn;
  logic [7:0]  srcEnable;
  logic        initDone;
  logic        eccSingle, eccMulti, pciAddrPar, pciDataPar, agpPar;
  logic        gartInvalid, pciTgtAbort, agpTgtAbort, agpReqValid;
  logic [31:0] agpReqAddr, apBase, apSize, topOfMem;
  logic [9:0]  statusClr;
  logic [9:0]  status;
  logic        serrN, serrOe;

  int   vecCount = 0;
  int   errCount = 0;
  logic [9:0] expStatus = '0;
  logic       expPulse = 1'b0;

  always #2.5 clk = ~clk;

  sysErrAgg i_sysErrAgg (
    .clk(clk), .rst(rst), .globalEn(globalEn), .srcEnable(srcEnable),
    .initDone(initDone), .eccSingle(eccSingle), .eccMulti(eccMulti),
    .pciAddrPar(pciAddrPar), .pciDataPar(pciDataPar), .agpPar(agpPar),
    .gartInvalid(gartInvalid), .pciTgtAbort(pciTgtAbort),
    .agpTgtAbort(agpTgtAbort), .agpReqValid(agpReqValid),
    .agpReqAddr(agpReqAddr), .apBase(apBase), .apSize(apSize),
    .topOfMem(topOfMem), .statusClr(statusClr), .status(status),
    .serrN(serrN), .serrOe(serrOe)
  );

  // Source events per R3, R7, R8 (bit i = source i)
  function automatic logic [9:0] srcModel();
    logic [32:0] endA;
    logic outside, illegal;
    endA    = {1'b0, apBase} + {1'b0, apSize};
    outside = agpReqValid && !((agpReqAddr >= apBase) && ({1'b0, agpReqAddr} < endA));
    illegal = outside && ((agpReqAddr >= 32'h000A_0000 && agpReqAddr <= 32'h000F_FFFF)
                          || agpReqAddr >= topOfMem);
    return {agpTgtAbort, pciTgtAbort, illegal, outside, gartInvalid, agpPar,
            pciDataPar, pciAddrPar, eccMulti & initDone, eccSingle & initDone};
  endfunction

  task automatic clearIn();
    eccSingle = 0; eccMulti = 0; pciAddrPar = 0; pciDataPar = 0; agpPar = 0;
    gartInvalid = 0; pciTgtAbort = 0; agpTgtAbort = 0; agpReqValid = 0;
    agpReqAddr = '0; statusClr = '0;
  endtask

  // Apply current inputs for one edge and check after it (R9, R10, R11, R12)
  task automatic step(input string tag);
    logic [9:0] ev;
    logic [9:0] en;
    ev = srcModel();
    en = {2'b11, srcEnable};
    if (rst) begin
      expStatus = '0;
      expPulse  = 1'b0;
    end else begin
      expPulse  = globalEn && (|(ev & en));
      expStatus = ev | (expStatus & ~statusClr);
    end
    @(posedge clk);
    @(negedge clk);
    vecCount++;
    if (status !== expStatus || serrN !== ~expPulse || serrOe !== expPulse) begin
      errCount++;
      $display("FAIL %s: status=%h exp=%h serrN=%b exp=%b serrOe=%b exp=%b",
               tag, status, expStatus, serrN, ~expPulse, serrOe, expPulse);
    end
  endtask

  task automatic agpAddr(input logic [31:0] a, input string tag);
    clearIn(); agpReqValid = 1; agpReqAddr = a; step(tag);
    clearIn(); statusClr = '1; step(tag);
  endtask

  initial begin
    #(200000 * 5);
    errCount++;
    $display("FAIL watchdog expired after %0d vectors (expected completion)", vecCount);
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    clearIn();
    rst = 1; globalEn = 1; srcEnable = '1; initDone = 1;
    apBase = 32'hE000_0000; apSize = 32'h1000_0000; topOfMem = 32'h0800_0000;
    @(negedge clk);
    // R12: events present during reset have no effect
    eccSingle = 1; pciTgtAbort = 1; gartInvalid = 1;
    step("R12 reset with events");
    step("R12 reset held");
    rst = 0; clearIn();
    step("R11 idle released");

    // R1: global enable off
    globalEn = 0;
    eccSingle = 1; eccMulti = 1; pciAddrPar = 1; pciDataPar = 1; agpPar = 1;
    gartInvalid = 1; pciTgtAbort = 1; agpTgtAbort = 1;
    agpReqValid = 1; agpReqAddr = 32'h000B_0000;
    step("R1 global off all sources");
    clearIn(); statusClr = '1;
    step("R10 clear all");
    globalEn = 1; clearIn();

    // R3: ECC before init
    initDone = 0; eccSingle = 1; eccMulti = 1;
    step("R3 ecc before init");
    step("R3 ecc before init repeat");
    initDone = 1;
    step("R2 ecc after init enabled");
    clearIn(); srcEnable = 8'b1111_1100; eccSingle = 1;
    step("R2 single ecc disabled");
    clearIn(); eccMulti = 1;
    step("R2 multi ecc disabled");
    clearIn(); srcEnable = 8'b0000_0010; eccMulti = 1; statusClr = '1;
    step("R2 multi ecc enabled, R10 set beats clear");

    // R4: target aborts ignore enables
    clearIn(); srcEnable = '0; statusClr = '1; pciTgtAbort = 1;
    step("R4 pci target abort");
    clearIn();
    step("R4 one clock only");
    agpTgtAbort = 1;
    step("R4 agp target abort");
    clearIn();
    step("R4 agp one clock only");

    // R5, R6: own enables
    pciAddrPar = 1; step("R5 addr parity disabled");
    clearIn(); srcEnable = 8'b0000_0100; pciAddrPar = 1; step("R5 addr parity enabled");
    clearIn(); pciDataPar = 1; step("R5 data parity other enable");
    clearIn(); srcEnable = 8'b0000_1000; pciDataPar = 1; step("R5 data parity enabled");
    clearIn(); srcEnable = 8'b0001_0000; agpPar = 1; step("R5 agp parity enabled");
    clearIn(); srcEnable = 8'b0001_0000; gartInvalid = 1; step("R6 gart disabled");
    clearIn(); srcEnable = 8'b0010_0000; gartInvalid = 1; statusClr = 10'b00_0010_0000;
    step("R6 gart enabled, R10 set beats clear");

    // R7, R8: decode boundaries, only illegal enabled
    srcEnable = 8'b1000_0000;
    agpAddr(32'hE000_0000, "R7 aperture base inside");
    agpAddr(32'hEFFF_FFFF, "R7 aperture last inside");
    agpAddr(32'hF000_0000, "R8 aperture end above tom");
    agpAddr(32'h0009_FFFF, "R8 below hole");
    agpAddr(32'h000A_0000, "R8 hole low");
    agpAddr(32'h000F_FFFF, "R8 hole high");
    agpAddr(32'h0010_0000, "R8 above hole");
    agpAddr(32'h07FF_FFFF, "R8 tom minus one");
    agpAddr(32'h0800_0000, "R8 tom");
    srcEnable = 8'b0100_0000;
    agpAddr(32'h0010_0000, "R7 outside enabled");
    agpAddr(32'hE800_0000, "R7 inside enabled");
    clearIn(); agpReqAddr = 32'h000B_0000; step("R7 invalid request ignored");
    apBase = 32'hF000_0000; apSize = 32'h1000_0000;
    agpAddr(32'hFFFF_FFFF, "R7 window to top of space");
    agpAddr(32'hEFFF_FFFF, "R7 below top window");
    apBase = 32'hE000_0000;

    // R9: pulse train
    srcEnable = '1; clearIn();
    gartInvalid = 1; step("R9 back to back 1");
    clearIn(); agpPar = 1; step("R9 back to back 2");
    clearIn(); eccSingle = 1; pciDataPar = 1; agpTgtAbort = 1; step("R9 same cycle merge");
    clearIn(); step("R9 gap");

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      globalEn  = (r[2:0] != 0);
      initDone  = (r[5:3] != 0);
      srcEnable = 8'($urandom);
      eccSingle = ($urandom_range(0, 7) == 0);
      eccMulti  = ($urandom_range(0, 7) == 0);
      pciAddrPar = ($urandom_range(0, 7) == 0);
      pciDataPar = ($urandom_range(0, 7) == 0);
      agpPar    = ($urandom_range(0, 7) == 0);
      gartInvalid = ($urandom_range(0, 7) == 0);
      pciTgtAbort = ($urandom_range(0, 11) == 0);
      agpTgtAbort = ($urandom_range(0, 11) == 0);
      statusClr = ($urandom_range(0, 3) == 0) ? 10'($urandom) : 10'd0;
      agpReqValid = r[6];
      case (r[9:7])
        3'd0: agpReqAddr = 32'hE000_0000 + {4'd0, 28'($urandom)};
        3'd1: agpReqAddr = 32'h000A_0000 + 32'($urandom_range(0, 32'h5FFFF));
        3'd2: agpReqAddr = 32'h0800_0000 + 32'($urandom_range(0, 32'h0100_0000));
        3'd3: agpReqAddr = 32'($urandom_range(0, 32'h0009_FFFF));
        3'd4: agpReqAddr = 32'($urandom_range(32'h0010_0000, 32'h07FF_FFFF));
        default: agpReqAddr = $urandom;
      endcase
      rst = ($urandom_range(0, 499) == 0);
      step("R9 R10 random");
    end
    rst = 0; clearIn();
    step("R11 final idle");

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end
endmodule